// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with 40-bit Accumulator

This block multiplies a signed 32-bit multiplier by a signed 32-bit multiplicand and adds the product into a 40-bit accumulator that it keeps inside. It has two operation modes. The full mode multiplies both 32-bit operands. Its 64-bit product is reduced to the low 40 bits before the add, and the operation takes two cycles. The half mode picks one signed 16-bit half of the multiplier, multiplies it by the whole multiplicand, and finishes in the cycle it is accepted.

An issue handshake (`issue_valid_i` / `issue_ready_o`) accepts one operation per cycle whenever the unit is not busy. `done_o` pulses in the cycle after each operation lands in the accumulator. Separate ports clear the accumulator, load it, and read it back sign-extended to 64 bits. The accumulator wraps with no saturation.

Top module: `mac40_unit`

## Requirements
- R1: With `mode_i`=0 (full mode), an accepted issue adds bits [39:0] of the signed 64-bit product `mulr_i`*`mulnd_i` to the accumulator on the clock edge after acceptance. `busy_o` is high for exactly that one cycle in between.
- R2: With `mode_i`=1 (half mode), `half_sel_i`=0 selects `mulr_i[15:0]` and `half_sel_i`=1 selects `mulr_i[31:16]`. The selected half is taken as signed, multiplied by signed `mulnd_i`, and the low 40 bits are added on the accepting edge. `busy_o` stays low.
- R3: Accumulation wraps modulo 2^40. For example 0x7F_FFFF_FFFF + 1 gives 0x80_0000_0000, and 0xFF_FFFF_FFFF + 1 gives 0.
- R4: `done_o` is high for one cycle after every accumulator update made by an operation, and is low at all other times.
- R5: `issue_ready_o` is the inverse of `busy_o`. An issue presented while busy is ignored and leaves no trace in the accumulator.
- R6: Operations issued back to back, including half-mode issues on consecutive cycles, are accumulated in issue order and none is lost.
- R7: `acc_wr_i` loads `acc_wdata_i` into the accumulator on the next edge. `acc_rdata_o` always shows the accumulator sign-extended from bit 39 to 64 bits.
- R8: `acc_clr_i` zeroes the accumulator on the next edge. The priority is clear, then load, then an operation result. A result that loses is discarded, but `done_o` still pulses.
- R9: After reset the accumulator reads 0, `busy_o` and `done_o` are low, and `issue_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation request |
| issue_ready_o | output | 1 | Unit can accept an operation this cycle |
| mode_i | input | 1 | 0: 32x32 mode, 1: 16x32 mode |
| half_sel_i | input | 1 | Half mode: 0 selects low multiplier half, 1 selects high |
| mulr_i | input | 32 | Signed multiplier |
| mulnd_i | input | 32 | Signed multiplicand |
| busy_o | output | 1 | Second cycle of a 32x32 operation is in progress |
| done_o | output | 1 | An operation updated the accumulator on the last edge |
| acc_clr_i | input | 1 | Clear accumulator |
| acc_wr_i | input | 1 | Load accumulator |
| acc_wdata_i | input | 40 | Load value |
| acc_rdata_o | output | 64 | Accumulator, sign-extended |

## Verification
The assertions assume the control inputs (`issue_valid_i`, `mode_i`, `acc_wr_i`, `acc_clr_i`) are known and not X from reset onward. The hold property also assumes the accumulator changes only through issues, loads and clears. The stimulus changes every input half a cycle away from the active edge, so operand and control values are settled when they are sampled. Clears and loads meet an operation's commit only in the single directed priority case. The bench keeps issuing with junk operands during a busy cycle, so the ignore rule is tested against live traffic and not an idle interface.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  localparam int unsigned OP_W_DEF  = 32;
  localparam int unsigned ACC_W_DEF = 40;
  localparam int unsigned RD_W_DEF  = 64;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_HALF = 1'b1
  } mode_e;
endpackage

// File: rtl/mac40_ctrl.sv
module mac40_ctrl
  import mac40_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_valid_i,
  input  logic mode_i,
  output logic start_full_o,
  output logic hi_phase_o,
  output logic commit_o,
  output logic busy_o,
  output logic done_o
);
  phase_e phase_q, phase_d;
  mode_e  mode;
  logic   accept;
  logic   done_q;

  assign mode   = mode_e'(mode_i);
  assign accept = issue_valid_i && (phase_q == PH_IDLE);

  assign start_full_o = accept && (mode == MODE_FULL);
  assign hi_phase_o   = (phase_q == PH_HIGH);
  // half mode commits on accept; full mode commits in its second cycle
  assign commit_o     = (accept && (mode == MODE_HALF)) || hi_phase_o;

  always_comb begin
    phase_d = PH_IDLE;
    if (start_full_o) phase_d = PH_HIGH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= commit_o;
    end
  end

  assign busy_o = hi_phase_o;
  assign done_o = done_q;
endmodule

// File: rtl/mac40_mul.sv
module mac40_mul
  import mac40_pkg::*;
#(
  parameter int unsigned OP_W  = OP_W_DEF,
  parameter int unsigned ACC_W = ACC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  mulr_i,
  input  logic [OP_W-1:0]  mulnd_i,
  input  logic             mode_i,
  input  logic             half_sel_i,
  input  logic             start_full_i,
  input  logic             hi_phase_i,
  output logic [ACC_W-1:0] addend_o
);
  localparam int unsigned HALF_W = OP_W / 2;
  localparam int unsigned B_W    = HALF_W + 1;
  localparam int unsigned PP_W   = OP_W + B_W;

  logic [OP_W-1:0]   mulnd_q;
  logic [HALF_W-1:0] hi_q;
  logic [ACC_W-1:0]  part_q;

  logic [OP_W-1:0]   a_sel;
  logic [B_W-1:0]    b_sel;
  logic [HALF_W-1:0] half_pick;
  logic [PP_W-1:0]   a_x, b_x, pp;
  logic [ACC_W-1:0]  pp_lo, pp_shift;

  assign half_pick = half_sel_i ? mulr_i[OP_W-1:HALF_W] : mulr_i[HALF_W-1:0];

  // one shared 32x17 signed multiplier serves all three uses
  always_comb begin
    if (hi_phase_i) begin
      a_sel = mulnd_q;
      b_sel = {hi_q[HALF_W-1], hi_q};
    end else if (mode_e'(mode_i) == MODE_FULL) begin
      a_sel = mulnd_i;
      b_sel = {1'b0, mulr_i[HALF_W-1:0]};
    end else begin
      a_sel = mulnd_i;
      b_sel = {half_pick[HALF_W-1], half_pick};
    end
  end

  assign a_x = {{(PP_W-OP_W){a_sel[OP_W-1]}}, a_sel};
  assign b_x = {{(PP_W-B_W){b_sel[B_W-1]}}, b_sel};
  assign pp  = a_x * b_x;

  assign pp_lo    = pp[ACC_W-1:0];
  assign pp_shift = {pp[ACC_W-HALF_W-1:0], {HALF_W{1'b0}}};

  assign addend_o = hi_phase_i ? (part_q + pp_shift) : pp_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mulnd_q <= '0;
      hi_q    <= '0;
      part_q  <= '0;
    end else if (start_full_i) begin
      mulnd_q <= mulnd_i;
      hi_q    <= mulr_i[OP_W-1:HALF_W];
      part_q  <= pp_lo;
    end
  end
endmodule

// File: rtl/mac40_acc.sv
module mac40_acc #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned RD_W  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [ACC_W-1:0] wdata_i,
  input  logic             commit_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic [RD_W-1:0]  rdata_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (wr_i)     acc_q <= wdata_i;
    else if (commit_i) acc_q <= acc_q + addend_i;  // wraps mod 2^ACC_W
  end

  generate
    if (RD_W > ACC_W) begin : g_sext
      assign rdata_o = {{(RD_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
    end else begin : g_trunc
      assign rdata_o = acc_q[RD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int unsigned OP_W  = OP_W_DEF,
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned RD_W  = RD_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  output logic             issue_ready_o,
  input  logic             mode_i,
  input  logic             half_sel_i,
  input  logic [OP_W-1:0]  mulr_i,
  input  logic [OP_W-1:0]  mulnd_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic             acc_clr_i,
  input  logic             acc_wr_i,
  input  logic [ACC_W-1:0] acc_wdata_i,
  output logic [RD_W-1:0]  acc_rdata_o
);
  logic             start_full, hi_phase, commit;
  logic [ACC_W-1:0] addend;

  mac40_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_valid_i (issue_valid_i),
    .mode_i        (mode_i),
    .start_full_o  (start_full),
    .hi_phase_o    (hi_phase),
    .commit_o      (commit),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  mac40_mul #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mulr_i       (mulr_i),
    .mulnd_i      (mulnd_i),
    .mode_i       (mode_i),
    .half_sel_i   (half_sel_i),
    .start_full_i (start_full),
    .hi_phase_i   (hi_phase),
    .addend_o     (addend)
  );

  mac40_acc #(.ACC_W(ACC_W), .RD_W(RD_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (acc_clr_i),
    .wr_i     (acc_wr_i),
    .wdata_i  (acc_wdata_i),
    .commit_i (commit),
    .addend_i (addend),
    .rdata_o  (acc_rdata_o)
  );

  assign issue_ready_o = !busy_o;
endmodule

// File: rtl/mac40_unit_chk.sv
module mac40_unit_chk #(
  parameter int unsigned OP_W  = 32,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned RD_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             issue_ready_o,
  input logic             mode_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             acc_clr_i,
  input logic             acc_wr_i,
  input logic [ACC_W-1:0] acc_wdata_i,
  input logic [RD_W-1:0]  acc_rdata_o
);
  assert_full_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o && !mode_i) |=> busy_o);

  assert_busy_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o && done_o));

  assert_half_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o && mode_i) |=> (done_o && !busy_o));

  assert_done_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) || $past(issue_valid_i && issue_ready_o && mode_i)));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !issue_valid_i && !acc_wr_i && !acc_clr_i) |=> $stable(acc_rdata_o));

  assert_sext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdata_o[RD_W-1:ACC_W] == {(RD_W-ACC_W){acc_rdata_o[ACC_W-1]}});

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && !acc_clr_i) |=> (acc_rdata_o[ACC_W-1:0] == $past(acc_wdata_i)));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr_i |=> (acc_rdata_o == '0));
endmodule

bind mac40_unit mac40_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .RD_W(RD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_ready_o (issue_ready_o),
  .mode_i        (mode_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .acc_clr_i     (acc_clr_i),
  .acc_wr_i      (acc_wr_i),
  .acc_wdata_i   (acc_wdata_i),
  .acc_rdata_o   (acc_rdata_o)
);

// File: tb/mac40_unit_tb.sv
`timescale 1ns/1ps
module mac40_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic        mode = 1'b0;
  logic        half_sel = 1'b0;
  logic [31:0] mulr = '0;
  logic [31:0] mulnd = '0;
  logic        busy, done;
  logic        acc_clr = 1'b0;
  logic        acc_wr = 1'b0;
  logic [39:0] acc_wdata = '0;
  logic [63:0] acc_rdata;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [39:0] acc_model = '0;
  logic [39:0] exp_q[$];

  always #10 clk = ~clk;

  mac40_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .mode_i(mode), .half_sel_i(half_sel),
    .mulr_i(mulr), .mulnd_i(mulnd),
    .busy_o(busy), .done_o(done),
    .acc_clr_i(acc_clr), .acc_wr_i(acc_wr), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata)
  );

  function automatic logic [63:0] sext(input logic [39:0] v);
    return {{24{v[39]}}, v};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each done cycle pops one expected accumulator value
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R4 spurious done", 64'd1, 64'd0);
      else chk("R6 scoreboard acc", acc_rdata, sext(exp_q.pop_front()));
    end
  end

  // driver: issue one operation, push expected accumulator after it
  task automatic issue_op(input bit half, input bit top, input logic [31:0] a_r,
                          input logic [31:0] b_nd, input bit spam);
    longint pa, pb, p;
    @(negedge clk);
    issue_valid = 1'b1; mode = half; half_sel = top; mulr = a_r; mulnd = b_nd;
    pb = longint'($signed(b_nd));
    if (half) pa = top ? longint'($signed(a_r[31:16])) : longint'($signed(a_r[15:0]));
    else pa = longint'($signed(a_r));
    p = pa * pb;
    acc_model = acc_model + p[39:0];
    exp_q.push_back(acc_model);
    @(posedge clk);
    if (!half) begin
      @(negedge clk);
      chk("R1 busy in second cycle", {63'd0, busy}, 64'd1);
      chk("R5 ready low while busy", {63'd0, issue_ready}, 64'd0);
      issue_valid = spam; mode = 1'b1; half_sel = 1'b1;
      mulr = 32'h7FFF_1234; mulnd = 32'h0BAD_F00D;
      @(posedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic load(input logic [39:0] v, input bit clr);
    @(negedge clk);
    issue_valid = 1'b0; acc_wr = 1'b1; acc_wdata = v; acc_clr = clr;
    @(negedge clk);
    acc_wr = 1'b0; acc_clr = 1'b0;
    acc_model = clr ? 40'd0 : v;
    if (clr) chk("R8 clear beats load", acc_rdata, 64'd0);
    else chk("R7 load and sign-extend", acc_rdata, sext(v));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 acc after reset", acc_rdata, 64'd0);
    chk("R9 busy after reset", {63'd0, busy}, 64'd0);
    chk("R9 done after reset", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", {63'd0, issue_ready}, 64'd1);

    // R1 full mode, several sign combinations
    issue_op(1'b0, 1'b0, 32'd3, 32'd5, 1'b0);
    issue_op(1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    issue_op(1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0);
    issue_op(1'b0, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 1'b0);
    issue_op(1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
    idle();
    // R5 issue while busy ignored
    issue_op(1'b0, 1'b0, 32'hFEDC_BA98, 32'h0000_1003, 1'b1);
    idle();
    // R2 half mode, both halves, negative halves; R6 back to back
    issue_op(1'b1, 1'b0, 32'h0001_8000, 32'h0000_0007, 1'b0);
    issue_op(1'b1, 1'b1, 32'h8000_0001, 32'hFFFF_FFF9, 1'b0);
    issue_op(1'b1, 1'b1, 32'h7FFF_0000, 32'h7FFF_FFFF, 1'b0);
    issue_op(1'b1, 1'b0, 32'hABCD_FFFF, 32'h8000_0000, 1'b0);
    issue_op(1'b0, 1'b0, 32'hC000_0003, 32'h4000_0005, 1'b0);
    issue_op(1'b1, 1'b0, 32'h0000_0100, 32'h0000_0100, 1'b0);
    idle();
    @(negedge clk);
    chk("R2 acc after half burst", acc_rdata, sext(acc_model));
    chk("R2 busy stays low in half mode", {63'd0, busy}, 64'd0);

    // R3 wraparound
    load(40'h7F_FFFF_FFFF, 1'b0);
    issue_op(1'b1, 1'b0, 32'd1, 32'd1, 1'b0);
    idle();
    @(negedge clk);
    chk("R3 wrap to negative", acc_rdata, 64'hFFFF_FF80_0000_0000);
    load(40'hFF_FFFF_FFFF, 1'b0);
    issue_op(1'b0, 1'b0, 32'd1, 32'd1, 1'b0);
    idle();
    @(negedge clk);
    chk("R3 wrap to zero", acc_rdata, 64'd0);

    // R8 clear with load, then load beats a commit
    load(40'h12_3456_789A, 1'b0);
    load(40'h55_5555_5555, 1'b1);
    @(negedge clk);
    issue_valid = 1'b1; mode = 1'b0; mulr = 32'd9; mulnd = 32'd9;
    exp_q.push_back(40'h80_0000_0042);
    @(negedge clk);
    issue_valid = 1'b0; acc_wr = 1'b1; acc_wdata = 40'h80_0000_0042;
    @(negedge clk);
    acc_wr = 1'b0;
    acc_model = 40'h80_0000_0042;
    chk("R8 load beats commit", acc_rdata, 64'hFFFF_FF80_0000_0042);

    repeat (4) @(negedge clk);
    chk("R4 no done when idle", {63'd0, done}, 64'd0);
    chk("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule